// File: doc/BRIEF.md
# DMA Dispatcher Control/Status Register File

This block is the software-facing register file of a descriptor-driven DMA dispatcher. A host on a simple 32-bit register bus reads a live status word, writes a control word, and reads the descriptor and response queue fill levels and the read and write sequence counters that the engine reports. Status flags for queue empty and full are derived inside the block from the fill levels against the configured queue depths.

Three sticky status flags are set by engine events and cleared by writing one to them: a pending-interrupt flag, a stopped-on-error flag and a stopped-on-early-termination flag. When the matching stop policy is enabled, an error or early-termination event also forces the stop bit of the control word, so dispatching halts until software clears it. The interrupt line is the pending flag gated by a global enable. Writing the reset bit of the control word starts a soft reset. The reset drives an output to the engine and shows as a "resetting" status for a fixed number of cycles. At the end it clears the control word and all sticky flags.

Top module: `dma_csr_ctrl`

## Requirements
- R1: After reset the control word reads 0, irq, soft_rst and halt are 0, and the status word shows only the flags derived from the current inputs.
- R2: Reads return a registered value one cycle after the read strobe. Byte offset 0x00 is status, 0x04 is control, 0x08 is {write-queue fill in 31:16, read-queue fill in 15:0}, 0x0C is the response fill in 15:0, 0x10 is {write sequence in 31:16, read sequence in 15:0}, and any other offset reads 0.
- R3: Status bit 1 (descriptor empty) is 1 when both descriptor fill levels are 0. Bit 2 (descriptor full) is 1 when either equals DESC_DEPTH. Bit 3 (response empty) is 1 when the response fill is 0. Bit 4 (response full) is 1 when it equals RESP_DEPTH.
- R4: The control word holds bit 0 stop, bit 2 stop-on-error, bit 3 stop-on-early, bit 4 global interrupt enable and bit 5 descriptor hold. Bit 1 reads as the resetting state and bits 31:6 read 0.
- R5: Status bit 9 (pending interrupt) is set by any done, error or early event. Writing 1 to bit 9 of the status word clears it. An event in the same cycle as the clear leaves it set.
- R6: The irq output is 1 exactly when status bit 9 and control bit 4 are both 1.
- R7: An error event with control bit 2 set sets control bit 0 and status bits 5 and 7. An early event with control bit 3 set sets control bit 0 and status bits 5 and 8. Without the policy bit, neither event touches the stop bit. A forced stop wins over a control write in the same cycle.
- R8: Status bits 7, 8 and 9 are write-one-to-clear. Writing 0 has no effect, and writing 0x3FF clears all three.
- R9: A control write with bit 1 set starts a soft reset. soft_rst and status bit 6 stay 1 for exactly RST_CYCLES cycles. When they drop, the control word and status bits 7 to 9 read 0.
- R10: While the soft reset runs, control writes and engine events change nothing.
- R11: The halt output is control bit 0 OR the resetting state, and the desc_hold output follows control bit 5.
- R12: Status bit 0 follows the eng_busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| eng_busy | input | 1 | Engine busy indication |
| desc_rd_fill | input | FILL_W | Read-side descriptor queue fill level |
| desc_wr_fill | input | FILL_W | Write-side descriptor queue fill level |
| resp_fill | input | FILL_W | Response queue fill level |
| rd_seq | input | SEQ_W | Read sequence counter |
| wr_seq | input | SEQ_W | Write sequence counter |
| evt_done | input | 1 | Transfer completion pulse |
| evt_error | input | 1 | Transfer error pulse |
| evt_early | input | 1 | Early termination pulse |
| irq | output | 1 | Level interrupt |
| soft_rst | output | 1 | Soft reset request to the engine |
| halt | output | 1 | Dispatching halted |
| desc_hold | output | 1 | Hold descriptor processing |

## Verification
Two pairs of functions can land on the same clock edge. One pair is a write-one-to-clear of the pending flag and a fresh event. The other is a control write that clears stop and an error event under the stop-on-error policy. The bench provokes each pair by driving the bus write and the event pulse in the same cycle. It then judges by reading back that the flag stays set and that the stop bit ends at 1. A third overlap, bus traffic during a soft reset, is judged by reading control and status inside the reset window.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

   // word index of each register (byte offset / 4)
   localparam int unsigned REG_STATUS = 0;
   localparam int unsigned REG_CTRL   = 1;
   localparam int unsigned REG_FILL   = 2;
   localparam int unsigned REG_RESP   = 3;
   localparam int unsigned REG_SEQ    = 4;

   // status bit positions
   localparam int unsigned ST_BUSY       = 0;
   localparam int unsigned ST_DESC_EMPTY = 1;
   localparam int unsigned ST_DESC_FULL  = 2;
   localparam int unsigned ST_RESP_EMPTY = 3;
   localparam int unsigned ST_RESP_FULL  = 4;
   localparam int unsigned ST_STOPPED    = 5;
   localparam int unsigned ST_RESETTING  = 6;
   localparam int unsigned ST_ERR_STOP   = 7;
   localparam int unsigned ST_EARLY_STOP = 8;
   localparam int unsigned ST_PEND       = 9;

   // control bit positions
   localparam int unsigned CT_STOP       = 0;
   localparam int unsigned CT_RESET      = 1;
   localparam int unsigned CT_STOP_ERR   = 2;
   localparam int unsigned CT_STOP_EARLY = 3;
   localparam int unsigned CT_GIE        = 4;
   localparam int unsigned CT_HOLD       = 5;

   typedef struct packed {
      logic hold;
      logic gie;
      logic stop_early;
      logic stop_err;
      logic stop;
   } ctrl_t;

endpackage

// File: rtl/dma_csr_rstseq.sv
module dma_csr_rstseq #(
   parameter int unsigned RST_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic done
);
   localparam int unsigned CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);

   generate
      if (RST_CYCLES < 1) begin : g_bad_len
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign done = active && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            cnt_q  <= CNT_W'(RST_CYCLES - 1);
         end
      end else if (done) begin
         active <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R9
   rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !active) |=> active);

   // R9
   rst_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (32'(cnt_q) < RST_CYCLES));

endmodule

// File: rtl/dma_csr_sticky.sv
module dma_csr_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_done,
   input  logic ev_err,
   input  logic ev_early,
   input  logic pol_err,
   input  logic pol_early,
   input  logic block,
   input  logic w1c_en,
   input  logic [2:0] w1c_bits,   // {pending, early, error}
   input  logic clear_all,
   output logic pend_q,
   output logic err_q,
   output logic early_q,
   output logic stop_req
);
   logic ev_any, err_set, early_set;

   assign ev_any    = !block && (ev_done || ev_err || ev_early);
   assign err_set   = !block && ev_err && pol_err;
   assign early_set = !block && ev_early && pol_early;
   assign stop_req  = err_set || early_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         err_q   <= 1'b0;
         early_q <= 1'b0;
      end else if (clear_all) begin
         pend_q  <= 1'b0;
         err_q   <= 1'b0;
         early_q <= 1'b0;
      end else begin
         if (ev_any)                        pend_q <= 1'b1;
         else if (w1c_en && w1c_bits[2])    pend_q <= 1'b0;
         if (err_set)                       err_q <= 1'b1;
         else if (w1c_en && w1c_bits[0])    err_q <= 1'b0;
         if (early_set)                     early_q <= 1'b1;
         else if (w1c_en && w1c_bits[1])    early_q <= 1'b0;
      end
   end

   // R5
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!block && (ev_done || ev_err || ev_early)) |=> pend_q);

   // R5
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_en && w1c_bits[2] && !ev_done && !ev_err && !ev_early) |=> !pend_q);

   // R10
   pend_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (block && !pend_q) |=> !pend_q);

endmodule

// File: rtl/dma_csr_ctl.sv
module dma_csr_ctl
   import dma_csr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  ctrl_t wr_val,
   input  logic  force_stop,
   input  logic  clear_all,
   output ctrl_t ctrl_q
);
   ctrl_t nxt;

   always_comb begin
      nxt = ctrl_q;
      if (wr_en)      nxt = wr_val;
      if (force_stop) nxt.stop = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctrl_q <= '0;
      else if (clear_all) ctrl_q <= '0;
      else                ctrl_q <= nxt;
   end

   // R4
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !force_stop && !clear_all) |=> $stable(ctrl_q));

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux
   import dma_csr_pkg::*;
#(
   parameter int unsigned IDX_W     = 3,
   parameter bit          RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  sel,
   input  logic [31:0]       w_status,
   input  logic [31:0]       w_ctrl,
   input  logic [31:0]       w_fill,
   input  logic [31:0]       w_resp,
   input  logic [31:0]       w_seq,
   output logic [31:0]       rdata
);
   logic [31:0] mux;

   always_comb begin
      mux = '0;
      if      (sel == IDX_W'(REG_STATUS)) mux = w_status;
      else if (sel == IDX_W'(REG_CTRL))   mux = w_ctrl;
      else if (sel == IDX_W'(REG_FILL))   mux = w_fill;
      else if (sel == IDX_W'(REG_RESP))   mux = w_resp;
      else if (sel == IDX_W'(REG_SEQ))    mux = w_seq;
   end

   generate
      if (RDATA_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= mux;
         end
      end else begin : g_comb
         logic unused_rd_pins;
         assign unused_rd_pins = clk ^ rst_n ^ rd_en;
         assign rdata = mux;
      end
   endgenerate

endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
   import dma_csr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned FILL_W     = 16,
   parameter int unsigned SEQ_W      = 16,
   parameter int unsigned DESC_DEPTH = 8,
   parameter int unsigned RESP_DEPTH = 8,
   parameter int unsigned RST_CYCLES = 8,
   parameter bit          RDATA_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              eng_busy,
   input  logic [FILL_W-1:0] desc_rd_fill,
   input  logic [FILL_W-1:0] desc_wr_fill,
   input  logic [FILL_W-1:0] resp_fill,
   input  logic [SEQ_W-1:0]  rd_seq,
   input  logic [SEQ_W-1:0]  wr_seq,
   input  logic              evt_done,
   input  logic              evt_error,
   input  logic              evt_early,
   output logic              irq,
   output logic              soft_rst,
   output logic              halt,
   output logic              desc_hold
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must be at least 5");
      end
      if (FILL_W > 16 || SEQ_W > 16) begin : g_bad_width
         $error("FILL_W and SEQ_W must not exceed 16");
      end
      if (DESC_DEPTH >= (1 << FILL_W) || RESP_DEPTH >= (1 << FILL_W)) begin : g_bad_depth
         $error("queue depth must fit in FILL_W");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic wr_status, wr_ctrl, rst_start, rst_active, rst_done;
   logic pend_q, err_q, early_q, stop_req;
   ctrl_t ctrl_q, ctrl_wr_val;
   logic desc_empty, desc_full, resp_empty, resp_full;
   logic [31:0] w_status, w_ctrl, w_fill, w_resp, w_seq;
   logic unused_bus_bits;

   assign idx       = bus_addr[ADDR_W-1:2];
   assign wr_status = bus_wr && (idx == IDX_W'(REG_STATUS));
   assign wr_ctrl   = bus_wr && (idx == IDX_W'(REG_CTRL)) && !rst_active;
   assign rst_start = wr_ctrl && bus_wdata[CT_RESET];
   assign unused_bus_bits = ^{bus_addr[1:0], bus_wdata[31:10], bus_wdata[6:0]};

   assign ctrl_wr_val = '{hold:       bus_wdata[CT_HOLD],
                          gie:        bus_wdata[CT_GIE],
                          stop_early: bus_wdata[CT_STOP_EARLY],
                          stop_err:   bus_wdata[CT_STOP_ERR],
                          stop:       bus_wdata[CT_STOP]};

   dma_csr_rstseq #(.RST_CYCLES(RST_CYCLES)) u_rstseq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (rst_start),
      .active (rst_active),
      .done   (rst_done)
   );

   dma_csr_sticky u_sticky (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_done   (evt_done),
      .ev_err    (evt_error),
      .ev_early  (evt_early),
      .pol_err   (ctrl_q.stop_err),
      .pol_early (ctrl_q.stop_early),
      .block     (rst_active),
      .w1c_en    (wr_status),
      .w1c_bits  (bus_wdata[ST_PEND:ST_ERR_STOP]),
      .clear_all (rst_done),
      .pend_q    (pend_q),
      .err_q     (err_q),
      .early_q   (early_q),
      .stop_req  (stop_req)
   );

   dma_csr_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_ctrl && !bus_wdata[CT_RESET]),
      .wr_val     (ctrl_wr_val),
      .force_stop (stop_req),
      .clear_all  (rst_done),
      .ctrl_q     (ctrl_q)
   );

   assign desc_empty = (desc_rd_fill == '0) && (desc_wr_fill == '0);
   assign desc_full  = (desc_rd_fill == FILL_W'(DESC_DEPTH)) ||
                       (desc_wr_fill == FILL_W'(DESC_DEPTH));
   assign resp_empty = (resp_fill == '0);
   assign resp_full  = (resp_fill == FILL_W'(RESP_DEPTH));

   always_comb begin
      w_status = '0;
      w_status[ST_BUSY]       = eng_busy;
      w_status[ST_DESC_EMPTY] = desc_empty;
      w_status[ST_DESC_FULL]  = desc_full;
      w_status[ST_RESP_EMPTY] = resp_empty;
      w_status[ST_RESP_FULL]  = resp_full;
      w_status[ST_STOPPED]    = ctrl_q.stop;
      w_status[ST_RESETTING]  = rst_active;
      w_status[ST_ERR_STOP]   = err_q;
      w_status[ST_EARLY_STOP] = early_q;
      w_status[ST_PEND]       = pend_q;
      w_ctrl = '0;
      w_ctrl[CT_STOP]       = ctrl_q.stop;
      w_ctrl[CT_RESET]      = rst_active;
      w_ctrl[CT_STOP_ERR]   = ctrl_q.stop_err;
      w_ctrl[CT_STOP_EARLY] = ctrl_q.stop_early;
      w_ctrl[CT_GIE]        = ctrl_q.gie;
      w_ctrl[CT_HOLD]       = ctrl_q.hold;
   end

   assign w_fill = {16'(desc_wr_fill), 16'(desc_rd_fill)};
   assign w_resp = {16'h0, 16'(resp_fill)};
   assign w_seq  = {16'(wr_seq), 16'(rd_seq)};

   dma_csr_rdmux #(.IDX_W(IDX_W), .RDATA_REG(RDATA_REG)) u_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (bus_rd),
      .sel      (idx),
      .w_status (w_status),
      .w_ctrl   (w_ctrl),
      .w_fill   (w_fill),
      .w_resp   (w_resp),
      .w_seq    (w_seq),
      .rdata    (bus_rdata)
   );

   assign irq       = pend_q && ctrl_q.gie;
   assign soft_rst  = rst_active;
   assign halt      = ctrl_q.stop || rst_active;
   assign desc_hold = ctrl_q.hold;

   // R7
   err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_error && ctrl_q.stop_err && !rst_active) |=> (ctrl_q.stop && err_q));

   // R7
   early_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_early && ctrl_q.stop_early && !rst_active) |=> (ctrl_q.stop && early_q));

   // R9
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_active) |-> (ctrl_q == '0 && !pend_q && !err_q && !early_q));

   // R10
   ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_active && $past(rst_active)) |-> $stable(ctrl_q));

endmodule

// File: tb/test_dma_csr_ctrl.sv
`timescale 1ns/1ps
module test_dma_csr_ctrl;
   localparam int unsigned DEPTH = 4;
   localparam int unsigned RSTC  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 0, bus_rd = 0;
   logic [4:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic eng_busy = 0;
   logic [7:0] desc_rd_fill = '0, desc_wr_fill = '0, resp_fill = '0;
   logic [7:0] rd_seq = '0, wr_seq = '0;
   logic evt_done = 0, evt_error = 0, evt_early = 0;
   logic irq, soft_rst, halt, desc_hold;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dma_csr_ctrl #(.ADDR_W(5), .FILL_W(8), .SEQ_W(8), .DESC_DEPTH(DEPTH),
                  .RESP_DEPTH(DEPTH), .RST_CYCLES(RSTC), .RDATA_REG(1'b1)) i_dma_csr_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
      .desc_rd_fill(desc_rd_fill), .desc_wr_fill(desc_wr_fill), .resp_fill(resp_fill),
      .rd_seq(rd_seq), .wr_seq(wr_seq), .evt_done(evt_done), .evt_error(evt_error),
      .evt_early(evt_early), .irq(irq), .soft_rst(soft_rst), .halt(halt), .desc_hold(desc_hold));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus/event cycle, starting and ending at a falling edge
   task automatic op(input bit wr, input bit rd, input logic [4:0] a, input logic [31:0] d,
                     input bit dn, input bit er, input bit ea);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      evt_done = dn; evt_error = er; evt_early = ea;
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; evt_done = 0; evt_error = 0; evt_early = 0;
   endtask

   task automatic wr32(input logic [4:0] a, input logic [31:0] d);
      op(1, 0, a, d, 0, 0, 0);
   endtask

   task automatic rd32(input logic [4:0] a, output logic [31:0] d);
      op(0, 1, a, '0, 0, 0, 0);
      d = bus_rdata;
   endtask

   function automatic logic [31:0] derived(input int rf, input int wf, input int pf);
      logic [31:0] s = '0;
      s[1] = (rf == 0 && wf == 0);
      s[2] = (rf == DEPTH || wf == DEPTH);
      s[3] = (pf == 0);
      s[4] = (pf == DEPTH);
      return s;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd32(5'h00, v); check("R1 status", v, 32'h00A);
      rd32(5'h04, v); check("R1 ctrl", v, 32'h0);
      check("R1 outputs", {28'h0, irq, soft_rst, halt, desc_hold}, 32'h0);

      // R12 busy mirror
      eng_busy = 1; rd32(5'h00, v); check("R12 busy=1", v, 32'h00B);
      eng_busy = 0; rd32(5'h00, v); check("R12 busy=0", v, 32'h00A);

      // R2 R3 fill sweep
      for (int rf = 0; rf <= DEPTH; rf++) begin
         for (int wf = 0; wf <= DEPTH; wf++) begin
            desc_rd_fill = 8'(rf); desc_wr_fill = 8'(wf);
            rd32(5'h00, v); check("R3 desc flags", v, derived(rf, wf, 0));
            rd32(5'h08, v); check("R2 fill word", v, (32'(wf) << 16) | 32'(rf));
         end
      end
      desc_rd_fill = 0; desc_wr_fill = 0;
      for (int pf = 0; pf <= DEPTH; pf++) begin
         resp_fill = 8'(pf);
         rd32(5'h00, v); check("R3 resp flags", v, derived(0, 0, pf));
         rd32(5'h0C, v); check("R2 resp word", v, 32'(pf));
      end
      resp_fill = 0;
      for (int s = 0; s < 256; s += 37) begin
         rd_seq = 8'(s); wr_seq = 8'(255 - s);
         rd32(5'h10, v); check("R2 seq word", v, (32'(255 - s) << 16) | 32'(s));
      end
      rd32(5'h14, v); check("R2 unmapped", v, 32'h0);
      rd32(5'h1C, v); check("R2 unmapped", v, 32'h0);

      // R4 R11 control word
      wr32(5'h04, 32'h3D); rd32(5'h04, v); check("R4 ctrl rw", v, 32'h3D);
      check("R11 halt/hold", {30'h0, halt, desc_hold}, 32'h3);
      wr32(5'h04, 32'hFFFF_FFFD); rd32(5'h04, v); check("R4 upper bits", v, 32'h3D);
      wr32(5'h04, 32'h0); rd32(5'h04, v); check("R4 ctrl clear", v, 32'h0);
      check("R11 halt/hold off", {30'h0, halt, desc_hold}, 32'h0);

      // R5 R6 pending flag and gating
      op(0, 0, 5'h00, 0, 1, 0, 0);
      rd32(5'h00, v); check("R5 done sets pend", v, 32'h20A);
      check("R6 irq gated off", {31'h0, irq}, 32'h0);
      wr32(5'h04, 32'h10); check("R6 irq on", {31'h0, irq}, 32'h1);
      wr32(5'h00, 32'h200); rd32(5'h00, v); check("R5 w1c pend", v, 32'h00A);
      check("R6 irq cleared", {31'h0, irq}, 32'h0);
      op(0, 0, 5'h00, 0, 0, 1, 0);
      rd32(5'h00, v); check("R7 error w/o policy", v, 32'h20A);
      op(1, 0, 5'h00, 32'h200, 0, 0, 1);
      rd32(5'h00, v); check("R5 set wins over clear", v, 32'h20A);
      wr32(5'h00, 32'h200);

      // R7 stop policies
      wr32(5'h04, 32'h14);
      op(0, 0, 5'h00, 0, 0, 1, 0);
      rd32(5'h04, v); check("R7 err forces stop", v, 32'h15);
      rd32(5'h00, v); check("R7 err status", v, 32'h2AA);
      check("R11 halt after err", {31'h0, halt}, 32'h1);
      wr32(5'h04, 32'h14); check("R11 halt released", {31'h0, halt}, 32'h0);
      rd32(5'h00, v); check("R8 err sticky", v, 32'h28A);
      wr32(5'h00, 32'h080); rd32(5'h00, v); check("R8 w1c err", v, 32'h20A);
      wr32(5'h04, 32'h18);
      op(0, 0, 5'h00, 0, 0, 0, 1);
      rd32(5'h00, v); check("R7 early status", v, 32'h32A);
      wr32(5'h04, 32'h14);
      op(1, 0, 5'h04, 32'h14, 0, 1, 0);
      rd32(5'h04, v); check("R7 stop wins over write", v, 32'h15);

      // R8 clear semantics
      wr32(5'h00, 32'h0); rd32(5'h00, v); check("R8 write zero", v, 32'h3AA);
      wr32(5'h00, 32'h3FF); rd32(5'h00, v); check("R8 clear all", v, 32'h02A);

      // R9 soft reset length and clearing
      op(0, 0, 5'h00, 0, 1, 0, 0);
      wr32(5'h04, 32'h02);
      n = 0;
      while (soft_rst && n < 50) begin n++; @(negedge clk); end
      check("R9 reset length", 32'(n), 32'(RSTC));
      rd32(5'h04, v); check("R9 ctrl cleared", v, 32'h0);
      rd32(5'h00, v); check("R9 status cleared", v, 32'h00A);

      // R10 writes and events ignored during reset
      wr32(5'h04, 32'h14);
      wr32(5'h04, 32'h02);
      op(1, 0, 5'h04, 32'h01, 1, 1, 0);
      rd32(5'h04, v); check("R10 ctrl frozen", v, 32'h16);
      rd32(5'h00, v); check("R10 events ignored", v, 32'h04A);
      while (soft_rst) @(negedge clk);
      rd32(5'h04, v); check("R9 ctrl cleared again", v, 32'h0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule